// File: doc/BRIEF.md
# Keyed Watchdog Timer

A 16-bit down-counting timer on a small 16-bit register bus. Software loads a reload value, picks a prescale ratio and starts the count; every prescaled step takes one off the count, and the step that brings it to zero raises an interrupt pulse. With auto-reload set, the count begins again from the reload value. Without it, the count stays at zero.

A sticky mode flag turns the timer into a watchdog. While the flag is set, an expiry also sends a one-cycle system-reset request. Software can set the flag at any time. Clearing it needs two writes to the mode register: the first must carry 0xF5 in its low byte and the second 0xA0. Any other low byte written straight after 0xF5 is treated as a tamper attempt and requests a reset at once.

Register map, as byte offsets on `bus_addr`: 0x00 is control, 0x04 writes the reload value and reads the live count, and 0x08 is the mode register. The interface accepts halfword accesses only.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, control reads 0x0002 (free-run set, everything else 0), the count reads 0, mode reads 0x8000, the reload value is 0xFFFF, and `irq` and `rst_req` are low.
- R2: A control write stores the prescale select from bits 11:9, auto-reload from bit 8, start from bit 7 and free-run from bit 1. A read returns these fields in the same positions, with all other bits 0.
- R3: A control write that sets start while start was clear loads the count from the reload value and clears the prescaler. Reading offset 0x04 returns the current count, and a write to 0x04 sets the reload value.
- R4: While start is set, the count falls by one every 2^(prescale+1) cycles with `tick_en` high. While start is clear, the count holds.
- R5: When a step takes the count from 1 to 0, `irq` is high for exactly the next cycle. With auto-reload the count becomes the reload value. Without it the count stays at 0 and no further `irq` follows.
- R6: An expiry while the mode flag is set also pulses `rst_req` for one cycle. With the flag clear, an expiry gives no `rst_req`.
- R7: A mode write with bit 15 set sets the flag. A write with bit 15 clear leaves it unchanged. Mode reads return the flag in bit 15.
- R8: A mode write with low byte 0xA0, when the previous mode write had low byte 0xF5, clears the flag. The stored byte is then cleared, so the next write is not taken as a second key.
- R9: A mode write whose low byte is not 0xA0, when the previous mode write had low byte 0xF5, pulses `rst_req` for one cycle. The low byte of every mode write is kept for the next comparison.
- R10: Accesses with `bus_size` other than 2'b01 (00 byte, 01 halfword, 10 word) are ignored: writes change nothing and reads return 0. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler tick enable |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the current access |
| irq | output | 1 | One-cycle expiry pulse |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The assertions check on every cycle that the interrupt is a single-cycle pulse that follows a count of one, and that every reset request traces back to a watchdog expiry or to a mode write made while the key was armed. They also check that the mode flag falls only on a correct second key word, that a stopped count holds, and that accesses of the wrong size leave the state alone. The bench scenarios show what the per-cycle checks cannot: the exact count after a given number of ticks at each prescale, the reload after expiry, and that a long random series of mode writes produces the right flag and reset pulses.

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int PW = 8,
  parameter logic [7:0] KEY_ARM = 8'hF5,
  parameter logic [7:0] KEY_CLR = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [AW-1:0] OFF_CTL  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_CNT  = AW'(8'h04);
  localparam logic [AW-1:0] OFF_MODE = AW'(8'h08);

  logic [2:0]    ctl_ps;
  logic          ctl_ar, ctl_st, ctl_free;
  logic [DW-1:0] reload_q, count_q;
  logic [PW-1:0] pre_q;
  logic          mode_q;
  logic [7:0]    last_q;

  logic acc, wr_ctl, wr_load, wr_mode;
  assign acc     = bus_sel && (bus_size == 2'b01);
  assign wr_ctl  = acc && bus_we && (bus_addr == OFF_CTL);
  assign wr_load = acc && bus_we && (bus_addr == OFF_CNT);
  assign wr_mode = acc && bus_we && (bus_addr == OFF_MODE);

  logic [PW:0] pre_lim;
  logic        run, pre_hit, step, expire;
  assign pre_lim = ((PW+1)'(2) << ctl_ps) - (PW+1)'(1);
  assign pre_hit = (pre_q == pre_lim[PW-1:0]);
  assign run     = ctl_st && !wr_ctl;
  assign step    = run && tick_en && pre_hit;
  assign expire  = step && (count_q == DW'(1));

  logic key_armed, key_ok, key_bad;
  assign key_armed = (last_q == KEY_ARM);
  assign key_ok    = wr_mode && key_armed && (bus_wdata[7:0] == KEY_CLR);
  assign key_bad   = wr_mode && key_armed && (bus_wdata[7:0] != KEY_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_ps   <= '0;
      ctl_ar   <= 1'b0;
      ctl_st   <= 1'b0;
      ctl_free <= 1'b1;
    end else if (wr_ctl) begin
      ctl_ps   <= bus_wdata[11:9];
      ctl_ar   <= bus_wdata[8];
      ctl_st   <= bus_wdata[7];
      ctl_free <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '1;
    else if (wr_load) reload_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pre_q   <= '0;
    end else if (wr_ctl && bus_wdata[7] && !ctl_st) begin
      count_q <= reload_q;
      pre_q   <= '0;
    end else if (run && tick_en) begin
      if (pre_hit) begin
        pre_q <= '0;
        if (count_q != '0)
          count_q <= (count_q == DW'(1) && ctl_ar) ? reload_q : count_q - DW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      last_q <= '0;
    end else if (wr_mode) begin
      mode_q <= key_ok ? 1'b0 : (mode_q | bus_wdata[15]);
      last_q <= key_ok ? 8'h00 : bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= expire;
      rst_req <= key_bad || (expire && mode_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc && !bus_we) begin
      case (bus_addr)
        OFF_CTL:  bus_rdata = DW'({4'b0, ctl_ps, ctl_ar, ctl_st, 5'b0, ctl_free, 1'b0});
        OFF_CNT:  bus_rdata = count_q;
        OFF_MODE: bus_rdata = DW'({mode_q, 15'b0});
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
`timescale 1ns/1ps
module wdt_keyed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [1:0]  bus_size,
  input logic [7:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        irq,
  input logic        rst_req,
  input logic        mode_q,
  input logic        ctl_st,
  input logic [15:0] count_q,
  input logic [7:0]  last_q
);
  logic mode_wr;
  assign mode_wr = bus_sel && bus_we && bus_size == 2'b01 && bus_addr == 8'h08;

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_from_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(count_q) == 16'd1);
  p_rst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ((irq && $past(mode_q)) || $past(mode_wr && last_q == 8'hF5)));
  p_key_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> $past(mode_wr && last_q == 8'hF5 && bus_wdata[7:0] == 8'hA0));
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_st && !$past(ctl_st)) |-> $stable(count_q));
  p_size_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_size != 2'b01) |=> ($stable(mode_q) && $stable(last_q) && $stable(ctl_st)));
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq(irq), .rst_req(rst_req), .mode_q(mode_q), .ctl_st(ctl_st),
  .count_q(count_q), .last_q(last_q)
);

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;
  logic clk = 0, rst_n = 0, tick_en = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_size = 2'b01;
  logic [7:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq, rst_req;
  int tests = 0, fails = 0;
  logic got_irq, got_rst;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  wdt_keyed u_wdt_keyed (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    tick_en = 0; bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk); #1;
    got_irq = irq; got_rst = rst_req;
    bus_sel = 0; bus_we = 0; bus_size = 2'b01;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    tick_en = 0; bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    got_irq = irq; got_rst = rst_req;
    bus_sel = 0; bus_size = 2'b01;
  endtask

  task automatic step(input logic t);
    @(negedge clk);
    tick_en = t;
    @(posedge clk); #1;
    got_irq = irq; got_rst = rst_req;
  endtask

  function automatic logic [15:0] exp_count(input int rl, input int ps, input int ticks);
    int n = rl - ticks / (2 << ps);
    return (n < 0) ? 16'd0 : 16'(n);
  endfunction

  function automatic logic [15:0] ctl_word(input int ps, input bit ar, input bit st, input bit fr);
    return 16'((ps << 9) | (int'(ar) << 8) | (int'(st) << 7) | (int'(fr) << 1));
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int irqs;
    bit m_mode;
    logic [7:0] m_last;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    rdr(8'h00, rd); check("R1 ctrl", rd, 16'h0002);
    rdr(8'h04, rd); check("R1 count", rd, 16'h0000);
    rdr(8'h08, rd); check("R1 mode", rd, 16'h8000);
    wr(8'h00, ctl_word(0, 0, 1, 1)); rdr(8'h04, rd); check("R1 reload FFFF", rd, 16'hFFFF);
    wr(8'h00, ctl_word(0, 0, 0, 1));

    // R2 control fields
    for (int i = 0; i < 20; i++) begin
      logic [15:0] d = 16'($urandom) & 16'hFF7F;
      wr(8'h00, d); rdr(8'h00, rd); check("R2 ctrl readback", rd, d & 16'h0F02);
    end

    // R10 wrong size and unmapped
    wr(8'h00, 16'h0102);
    wr(8'h00, 16'hFFFF, 2'b00); rdr(8'h00, rd); check("R10 byte write ignored", rd, 16'h0102);
    wr(8'h00, 16'hFFFF, 2'b10); rdr(8'h00, rd); check("R10 word write ignored", rd, 16'h0102);
    rdr(8'h00, rd, 2'b10); check("R10 word read zero", rd, 16'h0000);
    rdr(8'h0C, rd); check("R10 unmapped read", rd, 16'h0000);
    wr(8'h08, 16'h00F5, 2'b00); wr(8'h08, 16'h0012); check("R10 byte key ignored", got_rst, 0);

    // R3 / R4 counting at prescale 0 and 2
    wr(8'h04, 16'd5);
    wr(8'h00, ctl_word(0, 0, 1, 1)); rdr(8'h04, rd); check("R3 start loads", rd, 16'd5);
    repeat (4) step(1); rdr(8'h04, rd); check("R4 ps0 4 ticks", rd, exp_count(5, 0, 4));
    wr(8'h00, ctl_word(0, 0, 0, 1));
    repeat (6) step(1); rdr(8'h04, rd); check("R4 hold when stopped", rd, exp_count(5, 0, 4));
    repeat (3) step(0);
    wr(8'h00, ctl_word(2, 0, 1, 1)); rdr(8'h04, rd); check("R3 restart reloads", rd, 16'd5);
    repeat (16) step(1); rdr(8'h04, rd); check("R4 ps2 16 ticks", rd, exp_count(5, 2, 16));
    repeat (5) step(0); rdr(8'h04, rd); check("R4 no tick no step", rd, exp_count(5, 2, 16));
    wr(8'h00, ctl_word(2, 0, 1, 1)); rdr(8'h04, rd); check("R3 start while running no reload", rd, exp_count(5, 2, 16));
    wr(8'h00, ctl_word(0, 0, 0, 1));

    // R5 / R6 expiry without auto-reload, watchdog mode on
    wr(8'h04, 16'd2);
    wr(8'h00, ctl_word(0, 0, 1, 1));
    irqs = 0;
    repeat (3) begin step(1); irqs += int'(got_irq); end
    check("R5 no early irq", irqs, 0);
    step(1); check("R5 irq on expiry", got_irq, 1); check("R6 rst on expiry in mode", got_rst, 1);
    step(1); check("R5 irq one cycle", got_irq, 0); check("R6 rst one cycle", got_rst, 0);
    irqs = 0;
    repeat (12) begin step(1); irqs += int'(got_irq); end
    check("R5 no repeat irq", irqs, 0);
    rdr(8'h04, rd); check("R5 stays zero", rd, 16'd0);
    wr(8'h00, ctl_word(0, 0, 0, 1));

    // R8 key clears mode
    wr(8'h08, 16'h00F5); check("R8 first key no rst", got_rst, 0);
    wr(8'h08, 16'h00A0); check("R8 second key no rst", got_rst, 0);
    rdr(8'h08, rd); check("R8 mode cleared", rd, 16'h0000);
    wr(8'h08, 16'h0033); check("R8 key not reused", got_rst, 0);

    // R5 auto-reload, R6 no rst with mode off
    wr(8'h00, ctl_word(0, 1, 1, 1));
    repeat (3) step(1);
    step(1); check("R5 irq with reload", got_irq, 1); check("R6 no rst mode off", got_rst, 0);
    rdr(8'h04, rd); check("R5 reloaded", rd, 16'd2);
    repeat (3) step(1);
    step(1); check("R5 second irq", got_irq, 1);
    wr(8'h00, ctl_word(0, 0, 0, 1));

    // R7 sticky set
    wr(8'h08, 16'h0000); rdr(8'h08, rd); check("R7 zero keeps clear", rd, 16'h0000);
    wr(8'h08, 16'h8000); rdr(8'h08, rd); check("R7 set", rd, 16'h8000);
    wr(8'h08, 16'h0000); rdr(8'h08, rd); check("R7 zero no clear", rd, 16'h8000);

    // R9 wrong key
    wr(8'h08, 16'h00F5);
    wr(8'h08, 16'h0012); check("R9 wrong key rst", got_rst, 1);
    step(0); check("R9 rst one cycle", got_rst, 0);
    rdr(8'h08, rd); check("R9 mode kept", rd, 16'h8000);

    // R7 R8 R9 random mode writes against a model
    m_mode = 1; m_last = 8'h12;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      logic [1:0] sz;
      bit exp_rst;
      int pick = $urandom_range(0, 3);
      d = 16'($urandom);
      d[7:0] = (pick == 0) ? 8'hF5 : (pick == 1) ? 8'hA0 : d[7:0];
      sz = ($urandom_range(0, 5) == 0) ? 2'(($urandom_range(0, 1)) * 2) : 2'b01;
      exp_rst = 0;
      if (sz == 2'b01) begin
        if (m_last == 8'hF5 && d[7:0] == 8'hA0) begin m_mode = 0; m_last = 0; end
        else begin
          if (m_last == 8'hF5) exp_rst = 1;
          m_mode = m_mode | d[15];
          m_last = d[7:0];
        end
      end
      wr(8'h08, d, sz);
      check("R9 random rst", got_rst, exp_rst);
      rdr(8'h08, rd);
      check("R7 random mode", rd, {m_mode, 15'b0});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule